// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash and decides when a program or erase has finished. Once started, it reads the flash status byte in pairs from one fixed address. It compares the busy-toggle bit (bit 6) between the two reads of each pair. If the bit holds still, the operation has completed. If it moves, the controller looks at the timeout flag (bit 5) of the later read. A clear flag sends it back for another pair.

A set flag does not mean failure straight away. The toggle bit can stop in the same instant that the flag rises, so the controller first takes one more pair of reads as a recheck. It declares failure only if the bit is still moving in that pair. A failure raises a request for the reset command in the same cycle. There is also a limit on the number of ordinary polling pairs. It gives a failure when the timeout flag never rises, so the controller cannot wait forever. Command sequences and bus timing are handled elsewhere.

Top module: `tbpoll_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy`, `rd_req`, `done`, `fail` and `rst_cmd` are all low.
- R2: A high `start` while idle begins a poll. A `start` while `busy` is high has no effect, so the number of reads and the result of the poll in progress are unchanged.
- R3: `rd_req` stays high until a cycle in which `rd_rdy` is also high. That cycle is the only one in which `rd_data` is taken. Only one read is in flight at a time. `rd_addr` always shows the `STATUS_ADDR` parameter.
- R4: If bit 6 is equal in both reads of a pair, the controller pulses `done`.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 0, the controller starts a new pair of reads.
- R6: If bit 6 differs and bit 5 of the second read is 1, the controller takes one recheck pair. If bit 6 is equal in that pair, it pulses `done`.
- R7: If bit 6 still differs in the recheck pair, the controller pulses `fail`, with `rst_cmd` high in that same cycle.
- R8: `done` and `fail` are single-cycle pulses and never high together. `busy` is low while either is high, and the controller is back in idle.
- R9: If `MAX_POLLS` ordinary pairs (recheck pairs not counted) each show a toggle with bit 5 clear, the last of them ends in `fail` together with `rst_cmd`. A value of 0 for `MAX_POLLS` removes the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (taken only while idle) |
| busy | output | 1 | A poll is in progress |
| rd_req | output | 1 | Status read request, held until accepted |
| rd_addr | output | ADDR_W | Address of the status reads |
| rd_rdy | input | 1 | Read accepted; `rd_data` is valid in this cycle |
| rd_data | input | DATA_W | Status byte returned by the flash |
| done | output | 1 | One-cycle pulse: operation complete |
| fail | output | 1 | One-cycle pulse: operation failed |
| rst_cmd | output | 1 | One-cycle request to issue the reset command |

## Verification
The bench targets several corner cases. The first is a timeout flag that rises in the same pair as the last toggle and is followed by a quiet recheck. A design that fails at once on the flag would report `fail` there instead of `done`. The second is a toggle that persists through the recheck, where a missing or wrong `rst_cmd` shows up. The third is a run of toggling pairs with the flag clear that reaches the poll limit, where an off-by-one limit would change the read count. The bus model also inserts wait cycles and drives a misleading status byte while `rd_rdy` is low. A design that sampled early would see a false toggle. Extra `start` pulses during a poll would add reads if they were not ignored.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_EVAL   = 2'd3
  } tbp_state_e;

  // status bit at a given position of a byte (zero-extended to 16 bits)
  function automatic logic status_bit(input logic [15:0] b, input int pos);
    return b[pos];
  endfunction

  // a bit moved between two consecutive status reads
  function automatic logic bit_moved(input logic [15:0] a, input logic [15:0] b,
                                     input int pos);
    return a[pos] ^ b[pos];
  endfunction

endpackage

// File: rtl/tbp_reader.sv
module tbp_reader #(
  parameter int DATA_W   = 8,
  parameter int TOG_BIT  = 6,
  parameter int FLAG_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic              second,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic              fire,
  output logic              toggled,
  output logic              flag
);
  import tbp_pkg::*;

  logic [DATA_W-1:0] samp_a;
  logic [DATA_W-1:0] samp_b;

  assign rd_req = want;
  assign fire   = want & rd_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a <= '0;
      samp_b <= '0;
    end else if (fire) begin
      if (second) samp_b <= rd_data;
      else        samp_a <= rd_data;
    end
  end

  assign toggled = bit_moved(16'(samp_a), 16'(samp_b), TOG_BIT);
  assign flag    = status_bit(16'(samp_b), FLAG_BIT);

  // request is held until accepted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rdy) |=> rd_req);

  // a sample register changes only on an accepted read
  assert_sample_only_on_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(samp_a) && $stable(samp_b));

endmodule

// File: rtl/tbp_limit.sv
module tbp_limit #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);
  generate
    if (MAX_POLLS == 0) begin : g_unbounded
      assign at_limit = 1'b0;
    end else begin : g_bounded
      localparam int CW = $clog2(MAX_POLLS + 1);
      localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (bump)  cnt <= cnt + 1'b1;
      end

      assign at_limit = (cnt == LAST);

      // the counter never runs past the final allowed pair
      assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
      // no step is taken once the last pair is reached
      assert_no_bump_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit |-> !bump);
    end
  endgenerate

endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fire,
  input  logic toggled,
  input  logic flag,
  input  logic at_limit,
  output logic want,
  output logic second,
  output logic busy,
  output logic clear,
  output logic bump,
  output logic done,
  output logic fail,
  output logic rst_cmd
);
  import tbp_pkg::*;

  tbp_state_e state, state_nx;
  logic rechk, rechk_nx;
  logic done_nx, fail_nx;

  // named events
  logic eval;
  logic rechk_enter;
  logic give_up;

  assign eval        = (state == ST_EVAL);
  assign want        = (state == ST_FIRST) || (state == ST_SECOND);
  assign second      = (state == ST_SECOND);
  assign busy        = (state != ST_IDLE);
  assign clear       = (state == ST_IDLE) && start;
  assign rechk_enter = eval && toggled && !rechk && flag;
  assign give_up     = eval && toggled && (rechk || (!flag && at_limit));
  assign bump        = eval && toggled && !rechk && !flag && !at_limit;

  always_comb begin
    state_nx = state;
    rechk_nx = rechk;
    done_nx  = 1'b0;
    fail_nx  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_nx = ST_FIRST;
          rechk_nx = 1'b0;
        end
      end
      ST_FIRST:  if (fire) state_nx = ST_SECOND;
      ST_SECOND: if (fire) state_nx = ST_EVAL;
      ST_EVAL: begin
        if (!toggled) begin
          done_nx  = 1'b1;
          state_nx = ST_IDLE;
        end else if (give_up) begin
          fail_nx  = 1'b1;
          state_nx = ST_IDLE;
        end else begin
          if (rechk_enter) rechk_nx = 1'b1;
          state_nx = ST_FIRST;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rechk   <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      rst_cmd <= 1'b0;
    end else begin
      state   <= state_nx;
      rechk   <= rechk_nx;
      done    <= done_nx;
      fail    <= fail_nx;
      rst_cmd <= fail_nx;
    end
  end

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE) |=> (state == ST_FIRST));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_FIRST && !fire) |=> (state == ST_FIRST));
  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !toggled) |=> done);
  assert_repoll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && toggled && !flag && !rechk && !at_limit) |=> (want && !done && !fail));
  assert_recheck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rechk_enter |=> (want && !fail));
  assert_fail_recheck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && toggled && rechk) |=> (fail && rst_cmd));
  assert_rst_with_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |-> fail);
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  assert_idle_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

endmodule

// File: rtl/tbpoll_ctrl.sv
module tbpoll_ctrl #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 22,
  parameter int TOG_BIT  = 6,
  parameter int FLAG_BIT = 5,
  parameter int MAX_POLLS = 4096,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              fail,
  output logic              rst_cmd
);
  logic want, second, fire, toggled, flag;
  logic clear, bump, at_limit;

  assign rd_addr = STATUS_ADDR;

  tbp_reader #(
    .DATA_W  (DATA_W),
    .TOG_BIT (TOG_BIT),
    .FLAG_BIT(FLAG_BIT)
  ) u_reader (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want),
    .second (second),
    .rd_rdy (rd_rdy),
    .rd_data(rd_data),
    .rd_req (rd_req),
    .fire   (fire),
    .toggled(toggled),
    .flag   (flag)
  );

  tbp_limit #(
    .MAX_POLLS(MAX_POLLS)
  ) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .bump    (bump),
    .at_limit(at_limit)
  );

  tbp_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .fire    (fire),
    .toggled (toggled),
    .flag    (flag),
    .at_limit(at_limit),
    .want    (want),
    .second  (second),
    .busy    (busy),
    .clear   (clear),
    .bump    (bump),
    .done    (done),
    .fail    (fail),
    .rst_cmd (rst_cmd)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !rd_req && !done && !fail));

endmodule

// File: tb/test_tbpoll_ctrl.sv
module test_tbpoll_ctrl;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 22;
  localparam int LIMIT  = 3;
  localparam logic [ADDR_W-1:0] SADDR = 22'h00_0AAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_rdy = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic busy, rd_req, done, fail, rst_cmd;
  logic [ADDR_W-1:0] rd_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  tbpoll_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_POLLS(LIMIT), .STATUS_ADDR(SADDR)
  ) i_tbpoll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_rdy(rd_rdy), .rd_data(rd_data),
    .done(done), .fail(fail), .rst_cmd(rst_cmd)
  );

  // entry = {bit6, bit5}; entry 0 in the low bits
  function automatic logic [15:0] seq8(input logic [1:0] e0, e1, e2, e3, e4, e5);
    return {4'b0000, e5, e4, e3, e2, e1, e0};
  endfunction

  // vector fields: [25:10] sequence, [9:8] result (1 done, 2 fail), [7:4] reads, [3:0] wait cycles
  localparam logic [25:0] VECS [0:7] = '{
    {seq8(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00), 2'd1, 4'd2, 4'd0},  // R4 quiet low
    {seq8(2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00), 2'd1, 4'd2, 4'd1},  // R4 quiet high, R3 waits
    {seq8(2'b00, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00), 2'd1, 4'd4, 4'd0},  // R5 repoll
    {seq8(2'b00, 2'b11, 2'b01, 2'b01, 2'b00, 2'b00), 2'd1, 4'd4, 4'd2},  // R6 recheck quiet
    {seq8(2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 2'b00), 2'd2, 4'd4, 4'd0},  // R7 recheck toggles
    {seq8(2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10), 2'd2, 4'd6, 4'd1},  // R9 limit
    {seq8(2'b00, 2'b10, 2'b01, 2'b11, 2'b01, 2'b01), 2'd1, 4'd6, 4'd0},  // R5 then R6
    {seq8(2'b10, 2'b01, 2'b11, 2'b01, 2'b00, 2'b00), 2'd2, 4'd4, 4'd3}   // R7 with waits
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_byte(input logic [1:0] e);
    return {1'b0, e[1], e[0], 5'b01010};
  endfunction

  // result code: 1 done, 2 fail with rst_cmd, 3 fail without rst_cmd, 0 none
  task automatic run_seq(input logic [15:0] sq, input int nwait, input bit poke,
                         output int code, output int nreads, output int after);
    int idx = 0;
    int wcnt = 0;
    int loops = 0;
    code = 0;
    nreads = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (code == 0 && loops < 400) begin
      if (rd_rdy) begin
        nreads++;
        idx++;
        rd_rdy = 1'b0;
      end
      start = poke && busy;
      if (done) code = 1;
      else if (fail) code = rst_cmd ? 2 : 3;
      else if (rd_req) begin
        if (wcnt >= nwait) begin
          rd_rdy  = 1'b1;
          rd_data = (idx < 8) ? status_byte(sq[2*idx +: 2]) : 8'h00;
          wcnt    = 0;
        end else begin
          // misleading byte while not ready
          rd_data = (idx < 8) ? ~status_byte(sq[2*idx +: 2]) : 8'hFF;
          wcnt++;
        end
      end
      if (code == 0) begin
        @(negedge clk);
        loops++;
      end
    end
    start = 1'b0;
    @(negedge clk);
    after = {29'd0, busy, done, fail};
  endtask

  initial begin
    int code, nreads, after;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 done/fail/rst_cmd", {done, fail, rst_cmd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {busy, rd_req, done, fail}, 0);
    check("R3 rd_addr", int'(rd_addr), int'(SADDR));

    for (int v = 0; v < 8; v++) begin
      run_seq(VECS[v][25:10], int'(VECS[v][3:0]), 1'b0, code, nreads, after);
      check($sformatf("R4-R7/R9 vec%0d result", v), code, int'(VECS[v][9:8]));
      check($sformatf("R3 vec%0d reads", v), nreads, int'(VECS[v][7:4]));
      check($sformatf("R8 vec%0d pulse ends idle", v), after, 0);
    end

    // R2: start held high during a poll changes nothing
    run_seq(seq8(2'b00, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00), 1, 1'b1, code, nreads, after);
    check("R2 start while busy result", code, 1);
    check("R2 start while busy reads", nreads, 4);

    // R9: limit counter restarts on each new poll
    run_seq(seq8(2'b00, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01), 0, 1'b0, code, nreads, after);
    check("R9 counter cleared per poll", code, 1);
    check("R9 counter cleared reads", nreads, 6);

    // R3: no reads requested while idle
    repeat (4) @(negedge clk);
    check("R3 idle no request", {rd_req, busy}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule